// File: doc/BRIEF.md
# Transmit Frame Pulse Generator with Rate Stuffing

This block drives the active-low frame pulse that marks the first bit of every transmit frame at the data interface of a line transceiver. It runs on the bit clock and starts producing pulses as soon as reset is released, so a valid pulse train already exists before any link activation is requested. Each pulse lasts one bit clock.

In fixed-rate mode the pulses are 4702 bit clocks apart. In variable-rate mode the block compares the fill level of the external source's FIFO with a threshold at every frame boundary. When the FIFO is running low, the next frame is stretched by four stuff bits to 4706 bit clocks, which draws less payload per unit time and lets the source catch up. The decision is latched for the whole frame, so the pulse phase never jumps part-way through a frame. A status output shows whether the current frame is stuffed.

The control is a four-state machine. IDLE is held in reset. IDLE goes to SYNC on the first clock after reset. SYNC is the single bit with the pulse low, and it always goes to PAYLOAD. PAYLOAD counts the remaining base bits and at its last bit goes to STUFF if the frame is stuffed, otherwise back to SYNC. STUFF counts the extra bits and then returns to SYNC.

Top module: `tfp_gen`

## Requirements
- R1: While rst_n is low, frame_n is high and stuffed is low.
- R2: The first pulse (frame_n low) appears in the clock cycle that follows the first rising clock edge with rst_n high.
- R3: frame_n is low for exactly one clock cycle per pulse.
- R4: With var_mode low, consecutive pulses are exactly 4702 clock cycles apart and stuffed stays low, whatever fifo_level and stuff_thresh are.
- R5: With var_mode high and fifo_level strictly below stuff_thresh at the clock edge that starts a frame, that frame lasts 4706 cycles and stuffed is high during it.
- R6: With var_mode high and fifo_level equal to or above stuff_thresh at that edge, the frame lasts 4702 cycles and stuffed is low during it.
- R7: The stuff decision is taken only at the edge that starts a frame. Changes of fifo_level or stuff_thresh during a frame do not change its length, and stuffed does not change while frame_n is high.
- R8: A change of var_mode during a frame takes effect only from the next frame boundary. The length of the running frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| var_mode | input | 1 | 1 = variable-rate with stuffing, 0 = fixed-rate |
| fifo_level | input | LVL_W | Fill level of the source FIFO |
| stuff_thresh | input | LVL_W | Level below which a frame is stuffed |
| frame_n | output | 1 | Active-low frame pulse, one bit wide |
| stuffed | output | 1 | High while the current frame is a stuffed frame |

## Verification
A corrupted bit counter or state register shows up as a pulse interval other than 4702 or 4706. This is visible at the next pulse, so within one frame length. A machine stuck in a state shows no pulse for more than 4706 cycles. A wrong latch of the stuff decision shows up as a stuffed level that disagrees with the level and threshold presented at the frame-start edge, or as one that changes mid-frame. The next interval then has the wrong length.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PAYLOAD,
        ST_STUFF
    } tfp_state_e;
endpackage

// File: rtl/tfp_bit_counter.sv
module tfp_bit_counter #(
    parameter int BASE_LEN   = 4702,
    parameter int STUFF_BITS = 4,
    localparam int CNT_W     = $clog2(BASE_LEN + STUFF_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic base_end,
    output logic full_end
);
    localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(BASE_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(BASE_LEN + STUFF_BITS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    always_comb begin
        base_end = (cnt == LAST_BASE);
        full_end = (cnt == LAST_FULL);
    end
endmodule

// File: rtl/tfp_stuff_decide.sv
module tfp_stuff_decide #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             var_mode,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] stuff_thresh,
    output logic             stuff_q
);
    logic want;

    always_comb want = var_mode && (fifo_level < stuff_thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stuff_q <= 1'b0;
        else if (load) stuff_q <= want;
    end
endmodule

// File: rtl/tfp_gen.sv
module tfp_gen
    import tfp_pkg::*;
#(
    parameter int BASE_LEN   = 4702,
    parameter int STUFF_BITS = 4,
    parameter int LVL_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             var_mode,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] stuff_thresh,
    output logic             frame_n,
    output logic             stuffed
);
    tfp_state_e state, state_nx;
    logic base_end, full_end, at_boundary;

    always_comb at_boundary = (state_nx == ST_SYNC);

    tfp_bit_counter #(.BASE_LEN(BASE_LEN), .STUFF_BITS(STUFF_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (at_boundary),
        .base_end (base_end),
        .full_end (full_end)
    );

    tfp_stuff_decide #(.LVL_W(LVL_W)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (at_boundary),
        .var_mode     (var_mode),
        .fifo_level   (fifo_level),
        .stuff_thresh (stuff_thresh),
        .stuff_q      (stuffed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_SYNC;
            ST_SYNC:    state_nx = ST_PAYLOAD;
            ST_PAYLOAD: if (base_end) state_nx = stuffed ? ST_STUFF : ST_SYNC;
            ST_STUFF:   if (full_end) state_nx = ST_SYNC;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_n = (state != ST_SYNC);
    end
endmodule

// File: rtl/tfp_gen_chk.sv
module tfp_gen_chk #(
    parameter int BASE_LEN   = 4702,
    parameter int STUFF_BITS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic var_mode,
    input logic frame_n,
    input logic stuffed
);
    localparam int GW = $clog2(BASE_LEN + STUFF_BITS) + 1;
    localparam logic [GW-1:0] GAP_BASE = GW'(BASE_LEN);
    localparam logic [GW-1:0] GAP_FULL = GW'(BASE_LEN + STUFF_BITS);

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (!frame_n) begin
            gap  <= GW'(1);
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    // R3
    a_r3_one_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> frame_n);

    // R4 R5 R6: interval matches the stuff state of the frame just ended
    a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !frame_n) |-> (gap == ($past(stuffed) ? GAP_FULL : GAP_BASE)));

    // R7
    a_r7_stuff_held: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |-> $stable(stuffed));

    // R4 R8
    a_r4_fixed_no_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !$past(var_mode)) |-> !stuffed);
endmodule

bind tfp_gen tfp_gen_chk #(.BASE_LEN(BASE_LEN), .STUFF_BITS(STUFF_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .var_mode (var_mode),
    .frame_n  (frame_n),
    .stuffed  (stuffed)
);

// File: tb/tfp_gen_test.sv
module tfp_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       var_mode = 1'b0;
    logic [7:0] fifo_level = 8'd0;
    logic [7:0] stuff_thresh = 8'd100;
    logic       frame_n;
    logic       stuffed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tfp_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .var_mode     (var_mode),
        .fifo_level   (fifo_level),
        .stuff_thresh (stuff_thresh),
        .frame_n      (frame_n),
        .stuffed      (stuffed)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Called just after a pulse was sampled; runs to the next pulse.
    task automatic run_frame(input int exp_len, input bit exp_stuff, input string tag,
                             input int chg_at = 0, input logic [7:0] chg_lvl = 8'd0);
        int gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (gap == 1) check({tag, " R3 pulse width"}, int'(frame_n), 1);
            if (gap == 10) check({tag, " stuffed"}, int'(stuffed), int'(exp_stuff));
            if (chg_at != 0 && gap == chg_at) fifo_level = chg_lvl;
        end while (frame_n !== 1'b0 && gap < 6000);
        check({tag, " interval"}, gap, exp_len);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R1 frame_n in reset", int'(frame_n), 1);
        check("R1 stuffed in reset", int'(stuffed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first pulse", int'(frame_n), 0);
        check("R2 first frame unstuffed", int'(stuffed), 0);
    endtask

    task automatic t_fixed();
        fifo_level = 8'd0;
        run_frame(4702, 1'b0, "R4 fixed low level");
        run_frame(4702, 1'b0, "R4 fixed low level");
    endtask

    task automatic t_var_stuff();
        var_mode = 1'b1;
        run_frame(4702, 1'b0, "R8 mode change mid-frame");
        run_frame(4706, 1'b1, "R5 stuffed frame");
        run_frame(4706, 1'b1, "R5 stuffed frame");
    endtask

    task automatic t_var_nostuff();
        fifo_level = 8'd100;
        run_frame(4706, 1'b1, "R7 level change after decision");
        run_frame(4702, 1'b0, "R6 level equal to threshold");
        fifo_level = 8'd200;
        run_frame(4702, 1'b0, "R6 level above threshold");
    endtask

    task automatic t_midframe();
        fifo_level = 8'd10;
        run_frame(4702, 1'b0, "R6 frame before low level");
        run_frame(4706, 1'b1, "R7 level rises mid-frame", 50, 8'd200);
        run_frame(4702, 1'b0, "R7 following frame");
    endtask

    task automatic t_back_to_fixed();
        fifo_level = 8'd10;
        run_frame(4702, 1'b0, "R6 frame before low level");
        var_mode = 1'b0;
        run_frame(4706, 1'b1, "R8 fixed request mid stuffed frame");
        run_frame(4702, 1'b0, "R4 fixed again");
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_var_stuff();
        t_var_nostuff();
        t_midframe();
        t_back_to_fixed();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule